// File: doc/BRIEF.md
# Multi-mode SPI master controller

This block is the master side of a full-duplex synchronous serial link. The host sets up one transfer at a time: the clock polarity and phase, the character length, which slave to address, a clock divider and the word to send. It then pulses a start strobe. The block pulls one active-low select line low and generates the serial clock. It shifts the transmit word out on MOSI, most significant bit first, and at the same time shifts MISO into the same register. When the transfer ends it releases the select line and presents the received word together with a one-cycle done pulse.

The slave cannot stall the master: there is no acknowledgement and no flow control, so every transfer has a length fixed by its setup. The mode, length, slave and divider may all differ from one transfer to the next. While the block is idle, the serial clock follows the requested polarity, so a slave sees the correct idle level before its select line falls.

Top module: `spi_master_top`

## Requirements
- R1: After a transfer of L bits, `rx_o` holds the L bits sampled on MISO, first sample in bit L-1 and last sample in bit 0. Bits above L-1 are zero. `rx_o` takes this value in the cycle that `done_o` is high and holds it until the next transfer ends.
- R2: Each serial clock half period lasts `div_i`+1 clock cycles, using the value captured at start. While no transfer runs, `sclk_o` shows the `cpol_i` value sampled one cycle earlier. A transfer makes exactly 2L clock edges and `sclk_o` ends at the idle level.
- R3: In the cycle after an accepted start, select line `sel_i` (bit index of `ss_n_o`) goes low and every other line stays high. It stays low for (2L+1)×(`div_i`+1) cycles. At no time is more than one line low.
- R4: With `cpha_i`=0, MISO is sampled on leading (away-from-idle) clock edges and MOSI changes on trailing edges. With `cpha_i`=1, MOSI changes on leading edges and MISO is sampled on trailing edges.
- R5: MOSI sends `tx_i[L-1]` down to `tx_i[0]` in that order. The first bit is driven from the cycle the select line falls. Transmit bits above L-1 are not sent. MOSI changes only together with a serial clock edge or at the start of a transfer.
- R6: L is `len_i` (an unsigned bit count) limited to the range 4 to 16: values below 4 act as 4 and values above 16 act as 16.
- R7: `done_o` is high for exactly one cycle per transfer. That cycle is the first one in which all select lines are high again.
- R8: `busy_o` is high from the cycle after an accepted start through the done cycle and falls in the cycle after it. A start seen while `busy_o` is high is ignored: it does not alter the running transfer or start another. A start held high is accepted in the first idle cycle.
- R9: During reset, all select lines are high, `sclk_o`, `busy_o`, `done_o` are 0 and `rx_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, taken when idle |
| cpol_i | input | 1 | Clock idle level |
| cpha_i | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| len_i | input | 5 | Character length in bits (limited to 4..16) |
| sel_i | input | 2 | Index of slave to address |
| div_i | input | 8 | Half period minus one, in clock cycles |
| tx_i | input | 16 | Transmit word, right aligned |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| rx_o | output | 16 | Received word, right aligned |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_n_o | output | 4 | Active-low slave selects |

## Verification
All timing is counted from the edge that accepts start, which is cycle 0. Select, busy and the first MOSI bit change at that edge. Serial clock edge k lands at cycle (k+1)(D+1). Select release, done and the new received word appear at cycle (2L+1)(D+1), and busy falls one cycle after that. The bench model keeps its own cycle count from the accepted start. From that count and the requirements' formulas it derives each expected output and compares it with the ports at every falling clock edge. A behavioural slave drives MISO only on its own change edges, so each bit is stable for at least one cycle around the master's sampling edge.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick_o = run_i && (cnt_q == div_i);

  always_comb begin
    if (!run_i || tick_o) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] tx_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              sample_i,
  input  logic              change_i,
  input  logic              capture_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rx_o
);
  logic [DATA_W-1:0] sh_q, sh_d, rx_q, rx_d, justified;
  logic [LEN_W-1:0]  shamt;
  logic              mosi_q, mosi_d;

  assign shamt     = LEN_W'(DATA_W) - len_i;
  assign justified = tx_i << shamt;

  always_comb begin
    sh_d   = sh_q;
    mosi_d = mosi_q;
    rx_d   = rx_q;
    if (load_i) begin
      sh_d   = justified;
      mosi_d = justified[DATA_W-1];
    end else begin
      if (sample_i)  sh_d   = {sh_q[DATA_W-2:0], miso_i};
      if (change_i)  mosi_d = sh_q[DATA_W-1];
      if (capture_i) rx_d   = sh_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      mosi_q <= 1'b0;
      rx_q   <= '0;
    end else begin
      sh_q   <= sh_d;
      mosi_q <= mosi_d;
      rx_q   <= rx_d;
    end
  end

  assign mosi_o = mosi_q;
  assign rx_o   = rx_q;
endmodule

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
  import spi_master_pkg::*;
#(
  parameter int NSLV    = 4,
  parameter int SEL_W   = 2,
  parameter int DIV_W   = 8,
  parameter int DATA_W  = 16,
  parameter int LEN_W   = 5,
  parameter int MIN_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             tick_i,
  output logic             run_o,
  output logic             load_o,
  output logic [LEN_W-1:0] len_o,
  output logic             sample_o,
  output logic             change_o,
  output logic             capture_o,
  output logic [DIV_W-1:0] div_o,
  output logic             sclk_o,
  output logic [NSLV-1:0]  ss_n_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int ECNT_W = LEN_W + 1;

  seq_state_t        state_q, state_d;
  logic [LEN_W-1:0]  len_clamp, len_q;
  logic [DIV_W-1:0]  div_q;
  logic              cpha_q;
  logic [ECNT_W-1:0] ecnt_q, ecnt_d, two_len, last_edge;
  logic              sclk_q, sclk_d, busy_q, done_q, done_d;
  logic [NSLV-1:0]   ss_q, ss_d;
  logic              edge_tick, end_tick, accept;

  always_comb begin
    if (len_i < LEN_W'(MIN_LEN))     len_clamp = LEN_W'(MIN_LEN);
    else if (len_i > LEN_W'(DATA_W)) len_clamp = LEN_W'(DATA_W);
    else                             len_clamp = len_i;
  end

  assign accept    = (state_q == ST_IDLE) && start_i;
  assign two_len   = {len_q, 1'b0};
  assign last_edge = two_len - 1'b1;
  assign edge_tick = tick_i && (ecnt_q < two_len);
  assign end_tick  = tick_i && (ecnt_q == two_len);
  assign sample_o  = edge_tick && (ecnt_q[0] == cpha_q);
  assign change_o  = edge_tick && (ecnt_q[0] != cpha_q) && (ecnt_q != last_edge);
  assign capture_o = end_tick;
  assign load_o    = accept;
  assign len_o     = len_clamp;
  assign run_o     = (state_q == ST_RUN);
  assign div_o     = div_q;

  always_comb begin
    state_d = state_q;
    ecnt_d  = ecnt_q;
    sclk_d  = sclk_q;
    ss_d    = ss_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        sclk_d = cpol_i;
        if (start_i) begin
          state_d = ST_RUN;
          ecnt_d  = '0;
          ss_d    = ~(NSLV'(1) << sel_i);
        end
      end
      ST_RUN: begin
        if (edge_tick) begin
          sclk_d = ~sclk_q;
          ecnt_d = ecnt_q + 1'b1;
        end
        if (end_tick) begin
          ss_d    = '1;
          done_d  = 1'b1;
          state_d = ST_FIN;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ecnt_q  <= '0;
      sclk_q  <= 1'b0;
      ss_q    <= '1;
      done_q  <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ecnt_q  <= ecnt_d;
      sclk_q  <= sclk_d;
      ss_q    <= ss_d;
      done_q  <= done_d;
      busy_q  <= (state_d != ST_IDLE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= LEN_W'(MIN_LEN);
      div_q  <= '0;
      cpha_q <= 1'b0;
    end else if (accept) begin
      len_q  <= len_clamp;
      div_q  <= div_i;
      cpha_q <= cpha_i;
    end
  end

  assign sclk_o = sclk_q;
  assign ss_n_o = ss_q;
  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/spi_master_top.sv
module spi_master_top #(
  parameter int NSLV    = 4,
  parameter int DATA_W  = 16,
  parameter int DIV_W   = 8,
  parameter int MIN_LEN = 4,
  localparam int SEL_W  = $clog2(NSLV),
  localparam int LEN_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [DATA_W-1:0] tx_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NSLV-1:0]   ss_n_o
);
  logic             run, tick, load, sample, change, capture;
  logic [LEN_W-1:0] len_c;
  logic [DIV_W-1:0] div_l;

  spi_seq_ctrl #(
    .NSLV(NSLV), .SEL_W(SEL_W), .DIV_W(DIV_W),
    .DATA_W(DATA_W), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cpol_i(cpol_i),
    .cpha_i(cpha_i), .len_i(len_i), .sel_i(sel_i), .div_i(div_i),
    .tick_i(tick), .run_o(run), .load_o(load), .len_o(len_c),
    .sample_o(sample), .change_o(change), .capture_o(capture),
    .div_o(div_l), .sclk_o(sclk_o), .ss_n_o(ss_n_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  spi_half_timer #(.DIV_W(DIV_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .run_i(run), .div_i(div_l), .tick_o(tick)
  );

  spi_shift_unit #(.DATA_W(DATA_W), .LEN_W(LEN_W)) shift_i (
    .clk(clk), .rst_n(rst_n), .load_i(load), .tx_i(tx_i), .len_i(len_c),
    .sample_i(sample), .change_i(change), .capture_i(capture),
    .miso_i(miso_i), .mosi_o(mosi_o), .rx_o(rx_o)
  );
endmodule

// File: rtl/spi_master_chk.sv
module spi_master_chk #(
  parameter int NSLV = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy_o,
  input logic            done_o,
  input logic            sclk_o,
  input logic            mosi_o,
  input logic [NSLV-1:0] ss_n_o
);
  // R7
  done_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (&ss_n_o));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R3
  one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~ss_n_o) <= 1);

  // R8
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(done_o));

  // R5
  mosi_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mosi_o) && $past(busy_o)) |-> !$stable(sclk_o));

  // R3
  select_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(&ss_n_o) |-> busy_o);
endmodule

bind spi_master_top spi_master_chk #(.NSLV(NSLV)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o),
  .sclk_o(sclk_o), .mosi_o(mosi_o), .ss_n_o(ss_n_o)
);

// File: tb/spi_master_top_tb_top.sv
`timescale 1ns/1ps
module spi_master_top_tb_top;
  logic        clk, rst_n, start_i, cpol_i, cpha_i, miso_i;
  logic [4:0]  len_i;
  logic [1:0]  sel_i;
  logic [7:0]  div_i;
  logic [15:0] tx_i;
  logic        busy_o, done_o, sclk_o, mosi_o;
  logic [15:0] rx_o;
  logic [3:0]  ss_n_o;

  int checks = 0;
  int fails  = 0;
  logic [15:0] slave_word;

  spi_master_top dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cpol_i(cpol_i),
    .cpha_i(cpha_i), .len_i(len_i), .sel_i(sel_i), .div_i(div_i),
    .tx_i(tx_i), .busy_o(busy_o), .done_o(done_o), .rx_o(rx_o),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso_i), .ss_n_o(ss_n_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // reference model state
  bit          m_act;
  int          m_n, m_len, m_h, m_sel;
  bit          m_cpol, m_cpha;
  logic [15:0] m_tx, m_sw, m_rx;

  function automatic int clamp_len(input int l); // R6
    if (l < 4)  return 4;
    if (l > 16) return 16;
    return l;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_n = 0; m_cpol = 0; m_rx = '0;
      m_len = 4; m_h = 1; m_sel = 0; m_cpha = 0; m_tx = '0; m_sw = '0;
    end else if (!m_act) begin
      m_cpol = cpol_i;
      if (start_i) begin
        m_act = 1; m_n = 0; m_cpha = cpha_i; m_len = clamp_len(int'(len_i));
        m_h = int'(div_i) + 1; m_sel = int'(sel_i); m_tx = tx_i; m_sw = slave_word;
      end
    end else begin
      m_n++;
      if (m_n == (2*m_len+1)*m_h)
        m_rx = m_sw & 16'((32'd1 << m_len) - 1);
      if (m_n == (2*m_len+1)*m_h + 1) m_act = 0;
    end
  end

  // behavioural slave, acts at falling clock edges
  bit prev_sel, prev_sclk;
  int lc, tc;
  always @(negedge clk) begin
    bit selnow;
    selnow = rst_n && m_act && (ss_n_o[m_sel] == 1'b0);
    if (selnow && !prev_sel) begin
      lc = 0; tc = 0;
      if (!m_cpha) miso_i = m_sw[m_len-1];
    end else if (selnow && (sclk_o != prev_sclk)) begin
      if (sclk_o != m_cpol) begin
        lc++;
        if (m_cpha && lc <= m_len) miso_i = m_sw[m_len-lc];
      end else begin
        tc++;
        if (!m_cpha && tc < m_len) miso_i = m_sw[m_len-1-tc];
      end
    end
    prev_sel  = selnow;
    prev_sclk = sclk_o;
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      int ticks, e, bi;
      logic [3:0] ss_exp;
      bit sclk_exp;
      ss_exp = 4'hF; sclk_exp = m_cpol;
      if (m_act) begin
        ticks = m_n / m_h;
        e = (ticks < 2*m_len) ? ticks : 2*m_len;
        sclk_exp = m_cpol ^ e[0];
        if (ticks <= 2*m_len) ss_exp = ~(4'b1 << m_sel);
        if (ss_exp != 4'hF) begin
          if (!m_cpha) bi = e / 2;
          else         bi = (e == 0) ? 0 : (e + 1) / 2 - 1;
          if (bi > m_len - 1) bi = m_len - 1;
          chk("R5 R4 mosi", 32'(mosi_o), 32'(m_tx[m_len-1-bi]));
        end
      end
      chk("R2 R4 sclk", 32'(sclk_o), 32'(sclk_exp));
      chk("R3 select", 32'(ss_n_o), 32'(ss_exp));
      chk("R8 busy", 32'(busy_o), 32'(m_act));
      chk("R7 done", 32'(done_o), 32'(m_act && (m_n == (2*m_len+1)*m_h)));
      chk("R1 rx", 32'(rx_o), 32'(m_rx));
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic xfer(input bit pol, input bit pha, input int len, input int sel,
                      input int dv, input logic [15:0] tx, input logic [15:0] sw);
    @(negedge clk);
    cpol_i = pol; cpha_i = pha; len_i = 5'(len); sel_i = 2'(sel);
    div_i = 8'(dv); tx_i = tx; slave_word = sw;
    @(negedge clk);
    cpol_i = pol;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (m_act) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 0; cpol_i = 0; cpha_i = 0; len_i = 5'd8;
    sel_i = 0; div_i = 0; tx_i = '0; miso_i = 0; slave_word = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 reset select", 32'(ss_n_o), 32'hF);
    chk("R9 reset sclk", 32'(sclk_o), 0);
    chk("R9 reset busy", 32'(busy_o), 0);
    chk("R9 reset done", 32'(done_o), 0);
    chk("R9 reset rx", 32'(rx_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    xfer(0, 0, 8, 0, 1, 16'h00A5, 16'h003C);   // R1 R4 mode 0
    chk("R1 rx mode0", 32'(rx_o), 32'h3C);
    xfer(0, 1, 16, 1, 0, 16'hC3E1, 16'h5AF0);  // R4 mode 1, full length
    chk("R1 rx mode1", 32'(rx_o), 32'h5AF0);
    xfer(1, 0, 4, 2, 2, 16'hFFF9, 16'hFFF6);   // R5 upper tx bits unused
    chk("R1 rx mode2", 32'(rx_o), 32'h6);
    xfer(1, 1, 12, 3, 3, 16'h0B2D, 16'h0E71);  // R2 mode 3, slow clock
    chk("R1 rx mode3", 32'(rx_o), 32'hE71);
    xfer(0, 0, 2, 1, 0, 16'h000D, 16'h000B);   // R6 short clamps to 4
    chk("R6 rx short", 32'(rx_o), 32'hB);
    xfer(1, 0, 25, 0, 1, 16'h9A3C, 16'h6D21);  // R6 long clamps to 16
    chk("R6 rx long", 32'(rx_o), 32'h6D21);
    // R2 idle level follows polarity
    @(negedge clk); cpol_i = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 idle low", 32'(sclk_o), 0);
    // R8 start during busy ignored
    @(negedge clk);
    cpol_i = 0; cpha_i = 1; len_i = 5'd8; sel_i = 2'd2; div_i = 8'd1;
    tx_i = 16'h0096; slave_word = 16'h0069;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (7) @(negedge clk);
    tx_i = 16'h00FF; sel_i = 2'd0; len_i = 5'd4; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (m_act) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R8 ignored start rx", 32'(rx_o), 32'h69);
    chk("R8 ignored start idle", 32'(busy_o), 0);
    // R8 held start: back to back
    @(negedge clk);
    cpol_i = 1; cpha_i = 0; len_i = 5'd5; sel_i = 2'd3; div_i = 8'd0;
    tx_i = 16'h0015; slave_word = 16'h000A; start_i = 1'b1;
    repeat (30) @(negedge clk);
    start_i = 1'b0;
    while (m_act) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R8 back to back rx", 32'(rx_o), 32'hA);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: R8 run did not finish, actual=hung expected=done");
    summary();
    $finish;
  end
endmodule